// File: doc/BRIEF.md
# Fetch Thread Status Controller

This block holds one small state machine per hardware thread. Each machine decides whether the fetch unit may begin new work for its thread. It separates a thread that is ready to fetch right now (Running) from a thread that is live but waiting on the memory side (WaitingCache). It also tracks the Idle, Blocked, Squashing and TrapPending conditions.

The surrounding fetch logic supplies the following per-thread inputs:

- thread activation
- decode and drain stalls
- squash requests with redirect addresses from three pipeline sources: commit, execute and decode
- line-request issue and completion
- translation faults
- trap-handled notices
- the encoded status of that thread's cache request tracker

The block returns, per thread:

- the current state
- a fetch-permission flag
- the redirect address chosen at the most recent accepted squash
- a flag raised when the state machine and the request tracker disagree

The tracker itself is not part of the block. Only its status code enters.

Top module: `fetch_thread_status`

## Requirements
- R1: State codes are Idle=0, Running=1, WaitingCache=2, Blocked=3, Squashing=4, TrapPending=5. After synchronous reset every thread is Idle, with can_fetch=0, incons_err=0 and redirect_pc=0. An Idle thread moves to Running on thr_activate.
- R2: A Running thread moves to WaitingCache on line_req_issue. A WaitingCache thread returns to Running on line_req_done.
- R3: A WaitingCache thread moves to TrapPending on xlat_fault, and fault outranks both stall and completion. A TrapPending thread returns to Running on trap_done.
- R4: A decode stall or a drain stall moves Running or WaitingCache to Blocked. The stall outranks issue and completion. Blocked returns to Running in the first cycle in which both stalls are low.
- R5: Any squash request moves Running, WaitingCache, Blocked or TrapPending to Squashing, and it outranks every other event in that cycle. A squash seen while Idle is ignored: the state stays Idle and redirect_pc is unchanged.
- R6: Squashing lasts exactly one cycle and is always followed by Running. A squash request that arrives while Squashing has no effect on the state or on redirect_pc.
- R7: When several squash sources fire in one cycle, commit outranks execute and execute outranks decode. The winner's address is loaded into redirect_pc on entry to Squashing and is held until the next accepted squash.
- R8: Tracker status codes are idle=0, translation wait=1, response wait=2, retry wait=3, complete=4, failed=5, cancelled=6. can_fetch is 1 in the same cycle exactly when the state is Running and the tracker code is 0.
- R9: incons_err is registered. It is 1 in the cycle after the state was Running while the tracker code was 1, 2 or 3, or after the state was WaitingCache while the tracker code was 0. Otherwise it is 0.
- R10: Threads are independent: events on one thread never change another thread's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_activate | input | NUM_THREADS | Thread becomes active |
| dec_stall | input | NUM_THREADS | Downstream decode stall |
| drain_stall | input | NUM_THREADS | Drain stall |
| cmt_squash | input | NUM_THREADS | Squash request from commit |
| cmt_pc | input | NUM_THREADS*PC_W | Commit redirect address per thread |
| exe_squash | input | NUM_THREADS | Squash request from execute |
| exe_pc | input | NUM_THREADS*PC_W | Execute redirect address per thread |
| dcd_squash | input | NUM_THREADS | Squash request from decode |
| dcd_pc | input | NUM_THREADS*PC_W | Decode redirect address per thread |
| line_req_issue | input | NUM_THREADS | A line request was issued |
| line_req_done | input | NUM_THREADS | The line request completed |
| xlat_fault | input | NUM_THREADS | Translation fault on the request |
| trap_done | input | NUM_THREADS | Pending trap has been handled |
| trk_status | input | NUM_THREADS*3 | Cache request tracker status code per thread |
| state_o | output | NUM_THREADS*3 | Current state code per thread |
| can_fetch | output | NUM_THREADS | Fetch permitted this cycle |
| redirect_pc | output | NUM_THREADS*PC_W | Redirect address from the last accepted squash |
| incons_err | output | NUM_THREADS | State and tracker mismatch seen last cycle |

## Verification
The bench builds the block with NUM_THREADS=3 and PC_W=16. Three threads let the bench run thread 0 through the full transition table while thread 1 carries the priority and consistency tests and thread 2 stays idle as a witness for R10. The sixteen-bit addresses are distinct for each thread and each source, so a wrong winner or a wrong lane shows directly on redirect_pc. Same-cycle collisions are applied on purpose: squash against stall, fault against completion, stall against issue, and squash during Squashing.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  localparam int STATE_W = 3;
  localparam int REQ_W   = 3;
  localparam int N_SQ_SRC = 3;

  typedef enum logic [STATE_W-1:0] {
    TS_IDLE  = 3'd0,
    TS_RUN   = 3'd1,
    TS_WAIT  = 3'd2,
    TS_BLOCK = 3'd3,
    TS_FLUSH = 3'd4,
    TS_TRAP  = 3'd5
  } thr_state_e;

  typedef enum logic [REQ_W-1:0] {
    RQ_IDLE   = 3'd0,
    RQ_XLAT   = 3'd1,
    RQ_RESP   = 3'd2,
    RQ_RETRY  = 3'd3,
    RQ_DONE   = 3'd4,
    RQ_FAIL   = 3'd5,
    RQ_CANCEL = 3'd6
  } req_state_e;

  typedef struct packed {
    logic activate;
    logic dstall;
    logic drstall;
    logic issue;
    logic done;
    logic fault;
    logic trap_done;
  } thr_ev_t;

endpackage

// File: rtl/fsc_squash_arb.sv
module fsc_squash_arb #(
  parameter int PC_W  = 32,
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] req,            // index 0 = highest priority
  input  logic [PC_W-1:0]  pc_in [N_SRC],
  output logic             any_o,
  output logic [PC_W-1:0]  sel_pc_o
);

  // Walk from lowest to highest priority so the highest requester is last written.
  always_comb begin
    sel_pc_o = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (req[k]) sel_pc_o = pc_in[k];
    end
  end

  assign any_o = |req;

  always_comb begin
    if (req[0]) begin
      a_top_wins_r7: assert (sel_pc_o == pc_in[0]);
    end
  end

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  thr_ev_t          ev,
  input  logic             sq_any,
  input  logic [PC_W-1:0]  sq_pc,
  output thr_state_e       state_o,
  output logic [PC_W-1:0]  redir_o
);

  thr_state_e st_q, st_d;
  logic [PC_W-1:0] redir_q;
  logic stall;
  logic sq_ok;

  assign stall = ev.dstall | ev.drstall;
  assign sq_ok = (st_q == TS_RUN) || (st_q == TS_WAIT) ||
                 (st_q == TS_BLOCK) || (st_q == TS_TRAP);

  always_comb begin
    st_d = st_q;
    case (st_q)
      TS_IDLE:  if (ev.activate) st_d = TS_RUN;
      TS_RUN: begin
        if (sq_any)         st_d = TS_FLUSH;
        else if (stall)     st_d = TS_BLOCK;
        else if (ev.issue)  st_d = TS_WAIT;
      end
      TS_WAIT: begin
        if (sq_any)         st_d = TS_FLUSH;
        else if (ev.fault)  st_d = TS_TRAP;
        else if (stall)     st_d = TS_BLOCK;
        else if (ev.done)   st_d = TS_RUN;
      end
      TS_BLOCK: begin
        if (sq_any)         st_d = TS_FLUSH;
        else if (!stall)    st_d = TS_RUN;
      end
      TS_TRAP: begin
        if (sq_any)            st_d = TS_FLUSH;
        else if (ev.trap_done) st_d = TS_RUN;
      end
      TS_FLUSH: st_d = TS_RUN;
      default:  st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TS_IDLE;
      redir_q <= '0;
    end else begin
      st_q <= st_d;
      if (sq_any && sq_ok) redir_q <= sq_pc;
    end
  end

  assign state_o = st_q;
  assign redir_o = redir_q;

  p_flush_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == TS_FLUSH) |=> (st_q == TS_RUN));

  p_squash_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (sq_any && sq_ok) |=> (st_q == TS_FLUSH && redir_q == $past(sq_pc)));

  p_idle_ignores_squash_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == TS_IDLE && !ev.activate) |=> (st_q == TS_IDLE && $stable(redir_q)));

  p_fault_to_trap_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == TS_WAIT && ev.fault && !sq_any) |=> (st_q == TS_TRAP));

  p_stall_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == TS_RUN && stall && !sq_any) |=> (st_q == TS_BLOCK));

endmodule

// File: rtl/fsc_consist.sv
module fsc_consist
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  thr_state_e state_i,
  input  req_state_e trk_i,
  output logic       can_fetch_o,
  output logic       err_o
);

  logic trk_busy;
  logic mismatch;
  logic err_q;

  assign trk_busy = (trk_i == RQ_XLAT) || (trk_i == RQ_RESP) || (trk_i == RQ_RETRY);
  assign mismatch = ((state_i == TS_RUN)  && trk_busy) ||
                    ((state_i == TS_WAIT) && (trk_i == RQ_IDLE));

  assign can_fetch_o = (state_i == TS_RUN) && (trk_i == RQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= mismatch;
  end

  assign err_o = err_q;

  p_no_fetch_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    trk_busy |-> !can_fetch_o);

  p_wait_idle_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (state_i == TS_WAIT && trk_i == RQ_IDLE) |=> err_o);

endmodule

// File: rtl/fetch_thread_status.sv
module fetch_thread_status
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int PC_W        = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_THREADS-1:0]        thr_activate,
  input  logic [NUM_THREADS-1:0]        dec_stall,
  input  logic [NUM_THREADS-1:0]        drain_stall,
  input  logic [NUM_THREADS-1:0]        cmt_squash,
  input  logic [NUM_THREADS*PC_W-1:0]   cmt_pc,
  input  logic [NUM_THREADS-1:0]        exe_squash,
  input  logic [NUM_THREADS*PC_W-1:0]   exe_pc,
  input  logic [NUM_THREADS-1:0]        dcd_squash,
  input  logic [NUM_THREADS*PC_W-1:0]   dcd_pc,
  input  logic [NUM_THREADS-1:0]        line_req_issue,
  input  logic [NUM_THREADS-1:0]        line_req_done,
  input  logic [NUM_THREADS-1:0]        xlat_fault,
  input  logic [NUM_THREADS-1:0]        trap_done,
  input  logic [NUM_THREADS*REQ_W-1:0]  trk_status,
  output logic [NUM_THREADS*STATE_W-1:0] state_o,
  output logic [NUM_THREADS-1:0]        can_fetch,
  output logic [NUM_THREADS*PC_W-1:0]   redirect_pc,
  output logic [NUM_THREADS-1:0]        incons_err
);

  localparam int SW = STATE_W;
  localparam int RW = REQ_W;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thr_ev_t         ev;
    thr_state_e      st;
    req_state_e      trk;
    logic            sq_any;
    logic [PC_W-1:0] sq_pc;
    logic [PC_W-1:0] redir;
    logic [PC_W-1:0] src_pc [N_SQ_SRC];
    logic [N_SQ_SRC-1:0] src_req;

    assign ev.activate  = thr_activate[t];
    assign ev.dstall    = dec_stall[t];
    assign ev.drstall   = drain_stall[t];
    assign ev.issue     = line_req_issue[t];
    assign ev.done      = line_req_done[t];
    assign ev.fault     = xlat_fault[t];
    assign ev.trap_done = trap_done[t];

    assign trk = req_state_e'(trk_status[t*RW +: RW]);

    assign src_req   = {dcd_squash[t], exe_squash[t], cmt_squash[t]};
    assign src_pc[0] = cmt_pc[t*PC_W +: PC_W];
    assign src_pc[1] = exe_pc[t*PC_W +: PC_W];
    assign src_pc[2] = dcd_pc[t*PC_W +: PC_W];

    fsc_squash_arb #(.PC_W(PC_W), .N_SRC(N_SQ_SRC)) u_arb (
      .req      (src_req),
      .pc_in    (src_pc),
      .any_o    (sq_any),
      .sel_pc_o (sq_pc)
    );

    fsc_thread_fsm #(.PC_W(PC_W)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .ev      (ev),
      .sq_any  (sq_any),
      .sq_pc   (sq_pc),
      .state_o (st),
      .redir_o (redir)
    );

    fsc_consist u_chk (
      .clk         (clk),
      .rst         (rst),
      .state_i     (st),
      .trk_i       (trk),
      .can_fetch_o (can_fetch[t]),
      .err_o       (incons_err[t])
    );

    assign state_o[t*SW +: SW]       = st;
    assign redirect_pc[t*PC_W +: PC_W] = redir;

    p_cmt_redirect_r7: assert property (@(posedge clk) disable iff (rst)
      (cmt_squash[t] && (st == TS_RUN || st == TS_WAIT || st == TS_BLOCK || st == TS_TRAP))
      |=> (redirect_pc[t*PC_W +: PC_W] == $past(cmt_pc[t*PC_W +: PC_W])));

    p_fetch_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
      can_fetch[t] |-> (state_o[t*SW +: SW] == 3'd1));
  end

endmodule

// File: tb/fetch_thread_status_tb.sv
module fetch_thread_status_tb;

  localparam int T  = 3;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [T-1:0]    act, dst, drs, csq, esq, dsq, iss, dne, flt, tdn;
  logic [T*PW-1:0] cpc, epc, dpc;
  logic [T*3-1:0]  trk;
  logic [T*3-1:0]  st;
  logic [T-1:0]    cf, err;
  logic [T*PW-1:0] rpc;

  fetch_thread_status #(.NUM_THREADS(T), .PC_W(PW)) u_dut (
    .clk(clk), .rst(rst), .thr_activate(act), .dec_stall(dst), .drain_stall(drs),
    .cmt_squash(csq), .cmt_pc(cpc), .exe_squash(esq), .exe_pc(epc),
    .dcd_squash(dsq), .dcd_pc(dpc), .line_req_issue(iss), .line_req_done(dne),
    .xlat_fault(flt), .trap_done(tdn), .trk_status(trk), .state_o(st),
    .can_fetch(cf), .redirect_pc(rpc), .incons_err(err)
  );

  int nchk = 0;
  int nfail = 0;

  // events: act dst drs csq esq dsq iss dne flt tdn | trk | exp state | exp can_fetch
  localparam int NV = 23;
  localparam logic [16:0] VEC [NV] = '{
    {10'b0000000000, 3'd0, 3'd0, 1'b0},
    {10'b0001000000, 3'd0, 3'd0, 1'b0},  // R5 squash in Idle ignored
    {10'b1000000000, 3'd0, 3'd1, 1'b1},  // R1
    {10'b0100001000, 3'd0, 3'd3, 1'b0},  // R4 stall beats issue
    {10'b0100000000, 3'd0, 3'd3, 1'b0},
    {10'b0000000000, 3'd0, 3'd1, 1'b1},  // R4 release
    {10'b0000001000, 3'd0, 3'd2, 1'b0},  // R2
    {10'b0000000100, 3'd4, 3'd1, 1'b0},  // R2 done, R8 tracker not idle
    {10'b0000000000, 3'd0, 3'd1, 1'b1},  // R8
    {10'b0000001000, 3'd0, 3'd2, 1'b0},
    {10'b0000000010, 3'd1, 3'd5, 1'b0},  // R3
    {10'b0000000000, 3'd0, 3'd5, 1'b0},
    {10'b0000000001, 3'd0, 3'd1, 1'b1},  // R3 trap done
    {10'b0010000000, 3'd0, 3'd3, 1'b0},  // R4 drain
    {10'b0010100000, 3'd0, 3'd4, 1'b0},  // R5 squash beats stall
    {10'b0001000000, 3'd0, 3'd1, 1'b1},  // R6
    {10'b0000001000, 3'd0, 3'd2, 1'b0},
    {10'b0000000110, 3'd2, 3'd5, 1'b0},  // R3 fault beats done
    {10'b0000010000, 3'd0, 3'd4, 1'b0},  // R5 from trap
    {10'b0000000000, 3'd0, 3'd1, 1'b1},  // R6
    {10'b0000001000, 3'd0, 3'd2, 1'b0},
    {10'b0100000100, 3'd4, 3'd3, 1'b0},  // R4 stall beats done
    {10'b0000000000, 3'd0, 3'd1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expv);
    nchk++;
    if (actual !== expv) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, actual, expv, $time);
    end
  endtask

  task automatic clear_ev();
    act = '0; dst = '0; drs = '0; csq = '0; esq = '0; dsq = '0;
    iss = '0; dne = '0; flt = '0; tdn = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] st_of(input int t);
    return st[t*3 +: 3];
  endfunction

  function automatic logic [PW-1:0] rpc_of(input int t);
    return rpc[t*PW +: PW];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    clear_ev();
    trk = '0;
    for (int t = 0; t < T; t++) begin
      cpc[t*PW +: PW] = 16'hC000 + 16'(t);
      epc[t*PW +: PW] = 16'hE000 + 16'(t);
      dpc[t*PW +: PW] = 16'hD000 + 16'(t);
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int t = 0; t < T; t++) begin
      check("R1 state", 32'(st_of(t)), 32'd0);
      check("R1 redirect", 32'(rpc_of(t)), 32'd0);
    end
    check("R1 can_fetch", 32'(cf), 32'd0);
    check("R1 incons_err", 32'(err), 32'd0);

    // Table on thread 0
    for (int i = 0; i < NV; i++) begin
      {act[0], dst[0], drs[0], csq[0], esq[0], dsq[0], iss[0], dne[0], flt[0], tdn[0]} = VEC[i][16:7];
      trk[2:0] = VEC[i][6:4];
      step();
      check($sformatf("R1-table row %0d state", i), 32'(st_of(0)), 32'(VEC[i][3:1]));
      check($sformatf("R8 row %0d can_fetch", i), 32'(cf[0]), 32'(VEC[i][0]));
      check($sformatf("R9 row %0d incons_err", i), 32'(err[0]), 32'd0);
      if (i == 1) check("R5 idle squash keeps redirect", 32'(rpc_of(0)), 32'd0);
      if (i == 14) check("R7 execute redirect", 32'(rpc_of(0)), 32'hE000);
      if (i == 18) check("R7 decode redirect", 32'(rpc_of(0)), 32'hD000);
      clear_ev();
      trk[2:0] = '0;
    end

    // R10 other threads untouched
    check("R10 thread1 idle", 32'(st_of(1)), 32'd0);
    check("R10 thread2 idle", 32'(st_of(2)), 32'd0);
    check("R10 thread1 redirect", 32'(rpc_of(1)), 32'd0);

    // R7 priority on thread 1
    act[1] = 1'b1; step(); clear_ev();
    check("R1 thread1 run", 32'(st_of(1)), 32'd1);
    csq[1] = 1'b1; esq[1] = 1'b1; dsq[1] = 1'b1; step(); clear_ev();
    check("R7 all three -> commit", 32'(rpc_of(1)), 32'hC001);
    check("R5 state squashing", 32'(st_of(1)), 32'd4);
    check("R10 thread0 kept", 32'(rpc_of(0)), 32'hD000);
    step();
    esq[1] = 1'b1; dsq[1] = 1'b1; step(); clear_ev();
    check("R7 execute over decode", 32'(rpc_of(1)), 32'hE001);
    // R6 squash during Squashing ignored
    csq[1] = 1'b1; step(); clear_ev();
    check("R6 state after flush", 32'(st_of(1)), 32'd1);
    check("R6 redirect held", 32'(rpc_of(1)), 32'hE001);
    dsq[1] = 1'b1; step(); clear_ev();
    check("R7 decode alone", 32'(rpc_of(1)), 32'hD001);
    step();
    check("R6 back to run", 32'(st_of(1)), 32'd1);

    // R9 consistency on thread 1 (Running)
    for (int c = 1; c <= 3; c++) begin
      trk[5:3] = 3'(c); step();
      check($sformatf("R9 run with tracker %0d", c), 32'(err[1]), 32'd1);
      check("R8 no fetch while busy", 32'(cf[1]), 32'd0);
    end
    trk[5:3] = 3'd0; step();
    check("R9 cleared", 32'(err[1]), 32'd0);
    check("R8 fetch resumes", 32'(cf[1]), 32'd1);
    iss[1] = 1'b1; step(); clear_ev();
    check("R2 thread1 wait", 32'(st_of(1)), 32'd2);
    step();
    check("R9 wait with idle tracker", 32'(err[1]), 32'd1);
    trk[5:3] = 3'd2; step();
    check("R9 wait with busy tracker", 32'(err[1]), 32'd0);
    check("R10 thread2 still idle", 32'(st_of(2)), 32'd0);
    check("R10 thread2 no error", 32'(err[2]), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule